// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block is one transmit channel of a DMA engine. Software builds a ring of 8-byte descriptors in system memory. Each descriptor holds a control word followed by a buffer address word, both read as little-endian 32-bit words. Software then programs the ring base and a tail index through a four-register window. The channel walks the ring from its current pointer up to the tail. For each descriptor it reads the buffer one 32-bit word at a time and emits the bytes, lowest byte first, on a byte stream port. The first and last bytes of a frame are marked when the descriptor asks for it. A descriptor can also ask for a one-cycle completion interrupt.

An end-of-table flag in the descriptor wraps the pointer back to the ring base, so the ring length is set by the descriptors and not by a register. The channel can be paused at descriptor boundaries, flushed, or switched to loopback. Loopback sends the bytes to a separate strobe. The status register gives the pointer, a state code, an error code and a flush-done flag. The engine is an explicit state machine with nine states: OFF, DESC_CTL, DESC_ADR, WORD, SEND, DONE, IDLE, PAUSE and HALT.

Transitions:
- Clearing enable moves any state to OFF.
- From the boundary states (OFF with enable set, IDLE, PAUSE, DONE), the channel takes the first of these that applies:
  - a pending flush goes to IDLE;
  - suspend set goes to PAUSE;
  - a pointer that differs from the tail goes to DESC_CTL;
  - otherwise the channel goes to IDLE.
- DESC_CTL goes to DESC_ADR when the read returns.
- DESC_ADR goes to one of:
  - HALT, on a bad address;
  - DONE, on a zero byte count;
  - WORD, otherwise.
- WORD goes to SEND when the read returns.
- SEND returns to WORD after every fourth byte and goes to DONE after the last byte.
- HALT holds until enable is cleared.

Top module: `txd_channel`

## Requirements
- R1: After reset the status word reads 0, and `mem_req`, `out_valid`, `loop_valid` and `irq_done` are low.
- R2: Register offsets are 0x0 control, 0x4 ring base, 0x8 tail index and 0xC status (read-only). Control bit 0 is enable, bit 1 suspend, bit 2 loopback and bit 4 flush. The tail index keeps bits [11:3] and reads back with bits [2:0] zero.
- R3: The descriptor at ring base plus pointer is fetched as the control word at +0, then the address word at +4. Bytes come from buffer words fetched at bus address = buffer address + 0x4000_0000 (descriptor fetches use the same offset). Control bits [12:0] give the byte count, which may be zero. Bytes leave in address order, with the lowest byte of each word first. While a read is not yet returned, `mem_req` and `mem_addr` hold.
- R4: `out_sof` marks the first byte of a descriptor whose control bit 31 is set. `out_eof` marks its last byte when bit 30 is set.
- R5: After a descriptor completes, the pointer advances by 8, or returns to 0 when control bit 28 is set.
- R6: When the pointer equals the tail the state code is 2 (idle-wait). Writing a different tail restarts fetching.
- R7: A completed descriptor with control bit 29 set raises `irq_done` for exactly one cycle.
- R8: Setting suspend takes effect at the next descriptor boundary (state code 4, no further bytes). Clearing it resumes from the next descriptor.
- R9: A flush request at a boundary sets the pointer to the tail, sends no bytes and sets status bit 20. Bit 20 clears when the flush bit is cleared. A pending flush takes priority over suspend.
- R10: With loopback set, bytes are strobed on `loop_valid` instead of `out_valid`. The two are never high together.
- R11: A buffer address above 0x3FFF_FFFF gives error code 1, and an address not word aligned gives error code 2. Either one moves the channel to state code 3 (stopped).
- R12: Clearing enable makes the whole status word 0 on the next cycle.
- R13: Status bits [11:0] hold the pointer, [15:12] the state code (0 disabled, 1 active, 2 idle-wait, 3 stopped, 4 suspended), [19:16] the error code and bit 20 flush-done. Only code 1 issues requests or bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Memory read bus address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Transmit byte strobe |
| out_data | output | 8 | Byte value (shared with loopback) |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| loop_valid | output | 1 | Loopback byte strobe |
| irq_done | output | 1 | Completion interrupt pulse |

## Verification
A corrupted pointer shows up at the next descriptor. `mem_addr` goes to the wrong slot, and the bytes that follow differ from the bench's model of the ring within a few cycles. A wrong pointer is also visible in status bits [11:0] once the channel parks in idle-wait. A stuck or misrouted state shows up as a wrong state code, as bytes leaking while suspended or flushed, or as a missing or extra `irq_done`. A byte-count or lane-select fault changes the stream length or the byte order at the end of that descriptor.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [3:0] {
        S_OFF, S_DESC_CTL, S_DESC_ADR, S_WORD, S_SEND, S_DONE, S_IDLE, S_PAUSE, S_HALT
    } eng_state_t;

    localparam logic [3:0] CODE_OFF   = 4'd0;
    localparam logic [3:0] CODE_RUN   = 4'd1;
    localparam logic [3:0] CODE_WAIT  = 4'd2;
    localparam logic [3:0] CODE_HALT  = 4'd3;
    localparam logic [3:0] CODE_PAUSE = 4'd4;

    localparam logic [3:0] ERR_NONE  = 4'd0;
    localparam logic [3:0] ERR_RANGE = 4'd1;
    localparam logic [3:0] ERR_ALIGN = 4'd2;

    localparam int D_EOT = 28;
    localparam int D_IRQ = 29;
    localparam int D_EOF = 30;
    localparam int D_SOF = 31;

    typedef struct packed {
        logic flush;
        logic loop;
        logic pause;
        logic en;
    } chan_ctl_t;

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PTR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    input  logic [31:0]      stat,
    output chan_ctl_t        ctl,
    output logic [AW-1:0]    ring_base,
    output logic [PTR_W-1:0] tail,
    output logic [31:0]      rdata
);
    localparam logic [3:0] OFS_CTL  = 4'h0;
    localparam logic [3:0] OFS_BASE = 4'h4;
    localparam logic [3:0] OFS_TAIL = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl       <= '0;
            ring_base <= '0;
            tail      <= '0;
        end else if (we) begin
            unique case (addr)
                OFS_CTL:  ctl <= '{flush: wdata[4], loop: wdata[2], pause: wdata[1], en: wdata[0]};
                OFS_BASE: ring_base <= AW'(wdata);
                OFS_TAIL: tail <= {wdata[PTR_W-1:3], 3'b000};
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTL:  rdata = {27'b0, ctl.flush, 1'b0, ctl.loop, ctl.pause, ctl.en};
            OFS_BASE: rdata = 32'(ring_base);
            OFS_TAIL: rdata = 32'(tail);
            OFS_STAT: rdata = stat;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
#(
    parameter int            PTR_W    = 12,
    parameter int            CNT_W    = 13,
    parameter int            AW       = 32,
    parameter logic [AW-1:0] BUS_OFS  = 32'h4000_0000,
    parameter logic [AW-1:0] ADDR_MAX = 32'h3FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_ctl_t        ctl,
    input  logic [AW-1:0]    ring_base,
    input  logic [PTR_W-1:0] tail,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             loop_valid,
    output logic             irq_done,
    output logic [31:0]      stat
);
    localparam int DESC_BYTES = 8;

    eng_state_t        state, nstate;
    logic [PTR_W-1:0]  ptr, nxt_ptr;
    logic [CNT_W-1:0]  len, cnt;
    logic              d_eot, d_irq, d_eof, d_sof;
    logic [AW-1:0]     dbuf;
    logic [31:0]       word;
    logic [3:0]        err;
    logic              flushed;
    logic              at_edge, take_flush, last, bad_range, bad_align;

    // next-state decision
    always_comb begin
        nxt_ptr    = ptr;
        if (state == S_DONE)
            nxt_ptr = d_eot ? '0 : ptr + PTR_W'(DESC_BYTES);
        at_edge    = (state == S_OFF) || (state == S_IDLE) || (state == S_PAUSE) || (state == S_DONE);
        take_flush = ctl.en && at_edge && ctl.flush && !flushed;
        last       = (cnt == len - CNT_W'(1));
        bad_range  = AW'(mem_rdata) > ADDR_MAX;
        bad_align  = mem_rdata[1:0] != 2'b00;
        nstate     = state;
        if (!ctl.en) begin
            nstate = S_OFF;
        end else begin
            unique case (state)
                S_OFF, S_IDLE, S_PAUSE, S_DONE: begin
                    if (take_flush)          nstate = S_IDLE;
                    else if (ctl.pause)      nstate = S_PAUSE;
                    else if (nxt_ptr != tail) nstate = S_DESC_CTL;
                    else                     nstate = S_IDLE;
                end
                S_DESC_CTL: if (mem_rvalid) nstate = S_DESC_ADR;
                S_DESC_ADR: begin
                    if (mem_rvalid) begin
                        if (bad_range || bad_align) nstate = S_HALT;
                        else if (len == '0)         nstate = S_DONE;
                        else                        nstate = S_WORD;
                    end
                end
                S_WORD: if (mem_rvalid) nstate = S_SEND;
                S_SEND: begin
                    if (last)                  nstate = S_DONE;
                    else if (cnt[1:0] == 2'b11) nstate = S_WORD;
                end
                S_HALT: nstate = S_HALT;
                default: nstate = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nstate;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0; len <= '0; cnt <= '0; dbuf <= '0; word <= '0;
            d_eot <= 1'b0; d_irq <= 1'b0; d_eof <= 1'b0; d_sof <= 1'b0;
            err <= ERR_NONE; flushed <= 1'b0;
        end else if (!ctl.en) begin
            ptr <= '0; err <= ERR_NONE; flushed <= 1'b0;
        end else begin
            if (!ctl.flush) flushed <= 1'b0;
            if (take_flush) begin
                ptr     <= tail;
                flushed <= 1'b1;
            end else if (state == S_DONE) begin
                ptr <= nxt_ptr;
            end
            unique case (state)
                S_DESC_CTL: if (mem_rvalid) begin
                    len   <= mem_rdata[CNT_W-1:0];
                    d_eot <= mem_rdata[D_EOT];
                    d_irq <= mem_rdata[D_IRQ];
                    d_eof <= mem_rdata[D_EOF];
                    d_sof <= mem_rdata[D_SOF];
                end
                S_DESC_ADR: if (mem_rvalid) begin
                    dbuf <= AW'(mem_rdata);
                    cnt  <= '0;
                    if (bad_range)      err <= ERR_RANGE;
                    else if (bad_align) err <= ERR_ALIGN;
                end
                S_WORD: if (mem_rvalid) word <= mem_rdata;
                S_SEND: cnt <= cnt + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        logic [3:0] code;
        mem_req    = 1'b0;
        mem_addr   = '0;
        out_data   = word[{cnt[1:0], 3'b000} +: 8];
        out_valid  = (state == S_SEND) && !ctl.loop;
        loop_valid = (state == S_SEND) && ctl.loop;
        out_sof    = (state == S_SEND) && d_sof && (cnt == '0);
        out_eof    = (state == S_SEND) && d_eof && last;
        irq_done   = (state == S_DONE) && d_irq;
        code       = CODE_OFF;
        unique case (state)
            S_OFF:      code = CODE_OFF;
            S_DESC_CTL: begin code = CODE_RUN; mem_req = 1'b1; mem_addr = ring_base + BUS_OFS + AW'(ptr); end
            S_DESC_ADR: begin code = CODE_RUN; mem_req = 1'b1; mem_addr = ring_base + BUS_OFS + AW'(ptr) + AW'(4); end
            S_WORD:     begin code = CODE_RUN; mem_req = 1'b1; mem_addr = dbuf + BUS_OFS + AW'({cnt[CNT_W-1:2], 2'b00}); end
            S_SEND, S_DONE: code = CODE_RUN;
            S_IDLE:     code = CODE_WAIT;
            S_PAUSE:    code = CODE_PAUSE;
            S_HALT:     code = CODE_HALT;
            default:    code = CODE_OFF;
        endcase
        stat              = '0;
        stat[PTR_W-1:0]   = ptr;
        stat[15:12]       = code;
        stat[19:16]       = err;
        stat[20]          = flushed;
    end
endmodule

// File: rtl/txd_channel.sv
module txd_channel
    import txd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PTR_W = 12,
    parameter int CNT_W = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic          out_eof,
    output logic          loop_valid,
    output logic          irq_done
);
    chan_ctl_t        ctl_q;
    logic [AW-1:0]    ring_base;
    logic [PTR_W-1:0] tail;
    logic [31:0]      stat_word;
    logic             ctl_en;

    assign ctl_en = ctl_q.en;

    txd_regs #(.AW(AW), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .stat(stat_word), .ctl(ctl_q), .ring_base(ring_base), .tail(tail), .rdata(reg_rdata)
    );

    txd_engine #(.PTR_W(PTR_W), .CNT_W(CNT_W), .AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .ring_base(ring_base), .tail(tail),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .loop_valid(loop_valid), .irq_done(irq_done), .stat(stat_word)
    );
endmodule

// File: rtl/txd_channel_chk.sv
module txd_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_en,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          out_valid,
    input logic          loop_valid,
    input logic          out_sof,
    input logic          out_eof,
    input logic          irq_done,
    input logic [31:0]   stat_word
);
    a_r10_loop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && loop_valid));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (stat_word == 32'd0));

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && ctl_en) |=> (mem_req && $stable(mem_addr)));

    a_r4_marks_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> (out_valid || loop_valid));

    a_r11_halt_has_error: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[15:12] == 4'd3) |-> (stat_word[19:16] != 4'd0));

    a_r13_quiet_unless_active: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[15:12] != 4'd1) |-> (!mem_req && !out_valid && !loop_valid));

    a_r13_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[15:12] <= 4'd4);
endmodule

bind txd_channel txd_channel_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .out_valid(out_valid), .loop_valid(loop_valid),
    .out_sof(out_sof), .out_eof(out_eof), .irq_done(irq_done), .stat_word(stat_word)
);

// File: tb/tb_txd_channel.sv
`timescale 1ns/1ps
module tb_txd_channel;
    localparam logic [31:0] BUS  = 32'h4000_0000;
    localparam int          RING = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_sof, out_eof, loop_valid, irq_done;
    logic [7:0]  out_data;

    always #2.5 clk = ~clk;

    txd_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .loop_valid(loop_valid), .irq_done(irq_done)
    );

    logic [31:0] mem [0:2047];
    logic [10:0] got_q[$];
    logic [10:0] exp_q[$];
    int n_chk = 0, n_fail = 0;
    int irq_seen = 0, irq_exp = 0, bad_addr = 0;
    int unsigned lat = 0;
    int exp_ptr = 0, buf_no = 0;
    bit lb_mode = 0;

    // memory model with 0..2 cycle latency
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rst_n && mem_req) begin
            if (lat == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[11'((mem_addr - BUS) >> 2)];
                lat = $urandom % 3;
            end else lat = lat - 1;
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid || loop_valid) got_q.push_back({loop_valid, out_sof, out_eof, out_data});
            if (irq_done) irq_seen++;
            if (mem_req && mem_addr[31:30] != 2'b01) bad_addr++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_code(input int code);
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            rd(4'hC, s);
            if (s[15:12] == code) break;
        end
    endtask

    function automatic int next_ptr(input int p);
        return (p == 56) ? 0 : p + 8;
    endfunction

    task automatic put_raw(input logic [31:0] ctlw, input logic [31:0] adr);
        if (exp_ptr == 56) ctlw[28] = 1'b1;
        mem[(RING + exp_ptr) >> 2]     = ctlw;
        mem[(RING + exp_ptr + 4) >> 2] = adr;
        exp_ptr = next_ptr(exp_ptr);
    endtask

    task automatic add_desc(input int len, input bit sof, input bit eof, input bit irq, input bit expect_out);
        int b;
        b = 32'h800 + (buf_no % 64) * 64;
        buf_no++;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            mem[(b + i) >> 2][8 * ((b + i) % 4) +: 8] = v;
            if (expect_out) exp_q.push_back({lb_mode, sof && (i == 0), eof && (i == len - 1), v});
        end
        if (expect_out && irq) irq_exp++;
        put_raw({sof, eof, irq, 16'b0, 13'(len)}, b);
    endtask

    task automatic cmp_stream(input string req);
        bit ok;
        ok = (got_q.size() == exp_q.size());
        if (ok) foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) ok = 1'b0;
        check(ok, req, "byte stream (size)", got_q.size(), exp_q.size());
        got_q.delete(); exp_q.delete();
        check(irq_seen == irq_exp, "R7", "irq pulses", irq_seen, irq_exp);
        irq_seen = 0; irq_exp = 0;
    endtask

    task automatic finish_round(input string req);
        logic [31:0] s;
        wr(4'h8, exp_ptr);
        wait_code(2);
        rd(4'hC, s);
        check(s[15:12] == 2, "R6", "idle code", s[15:12], 2);
        check(s[11:0] == exp_ptr, "R5", "pointer", s[11:0], exp_ptr);
        cmp_stream(req);
    endtask

    task automatic run_round(input int n);
        for (int k = 0; k < n; k++)
            add_desc(1 + $urandom % 48, $urandom % 2, $urandom % 2, $urandom % 2, 1'b1);
        finish_round("R3/R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'hC, s);
        check(s == 0, "R1", "status after reset", s, 0);
        check(!mem_req && !out_valid && !loop_valid && !irq_done, "R1", "outputs after reset",
              {mem_req, out_valid, loop_valid, irq_done}, 0);

        // R2 register window
        wr(4'h8, 32'hFF); rd(4'h8, s);
        check(s == 32'hF8, "R2", "tail readback", s, 32'hF8);
        wr(4'h8, 0);
        wr(4'h4, RING); rd(4'h4, s);
        check(s == RING, "R2", "base readback", s, RING);
        wr(4'h0, 32'h1); rd(4'h0, s);
        check(s == 1, "R2", "control readback", s, 1);
        wait_code(2);
        rd(4'hC, s);
        check(s == 32'h2000, "R13", "idle status", s, 32'h2000);

        // directed: lengths 1, 4, 7 and zero-length with irq
        add_desc(1, 1, 1, 1, 1);
        add_desc(4, 1, 0, 0, 1);
        add_desc(7, 0, 1, 1, 1);
        add_desc(0, 0, 0, 1, 1);
        finish_round("R3/R4");

        // random rounds, crossing the end-of-table wrap
        for (int r = 0; r < 8; r++) run_round(1 + $urandom % 5);

        // R10 loopback
        lb_mode = 1'b1; wr(4'h0, 32'h5);
        run_round(3);
        lb_mode = 1'b0; wr(4'h0, 32'h1);

        // R8 suspend at a boundary mid-descriptor
        begin
            int after_a;
            add_desc(40, 1, 1, 0, 1);
            after_a = exp_ptr;
            add_desc(5, 1, 1, 1, 1);
            wr(4'h8, exp_ptr);
            for (int i = 0; i < 500; i++) begin @(negedge clk); if (got_q.size() > 0) break; end
            wr(4'h0, 32'h3);
            wait_code(4);
            rd(4'hC, s);
            check(s[15:12] == 4, "R8", "suspended code", s[15:12], 4);
            check(s[11:0] == after_a, "R8", "pointer at boundary", s[11:0], after_a);
            check(got_q.size() == 40, "R8", "bytes before pause", got_q.size(), 40);
            wr(4'h0, 32'h1);
            wait_code(2);
            cmp_stream("R8");
        end

        // R9 flush while suspended (flush wins)
        wr(4'h0, 32'h3);
        wait_code(4);
        add_desc(6, 1, 1, 1, 0);
        add_desc(9, 1, 1, 1, 0);
        wr(4'h8, exp_ptr);
        repeat (10) @(negedge clk);
        check(got_q.size() == 0, "R8", "no bytes while suspended", got_q.size(), 0);
        wr(4'h0, 32'h11);
        wait_code(2);
        rd(4'hC, s);
        check(s[20] == 1'b1, "R9", "flush-done bit", s[20], 1);
        check(s[11:0] == exp_ptr, "R9", "pointer moved to tail", s[11:0], exp_ptr);
        check(got_q.size() == 0 && irq_seen == 0, "R9", "flushed bytes", got_q.size(), 0);
        wr(4'h0, 32'h1);
        rd(4'hC, s);
        check(s[20] == 1'b0, "R9", "flush-done cleared", s[20], 0);

        // R11 address range error
        put_raw(32'h0000_0004, 32'h4000_0000);
        wr(4'h8, exp_ptr);
        wait_code(3);
        rd(4'hC, s);
        check(s[15:12] == 3 && s[19:16] == 1, "R11", "range error status", s[19:12], 8'h13);

        // R12 disable clears
        wr(4'h0, 32'h0);
        rd(4'hC, s);
        check(s == 0, "R12", "status after disable", s, 0);

        // R11 misaligned buffer
        wr(4'h8, 0); exp_ptr = 0;
        put_raw(32'h0000_0004, 32'h0000_0802);
        wr(4'h0, 32'h1);
        wr(4'h8, exp_ptr);
        wait_code(3);
        rd(4'hC, s);
        check(s[15:12] == 3 && s[19:16] == 2, "R11", "align error status", s[19:12], 8'h23);
        check(got_q.size() == 0, "R11", "no bytes on error", got_q.size(), 0);

        // recovery
        wr(4'h0, 32'h0); wr(4'h8, 0); exp_ptr = 0; got_q.delete(); irq_seen = 0;
        wr(4'h0, 32'h1);
        for (int r = 0; r < 3; r++) run_round(1 + $urandom % 6);

        check(bad_addr == 0, "R3", "bus address offset", bad_addr, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule